// File: doc/BRIEF.md
# Infrared Remote Pulse-Width Transceiver

This peripheral handles infrared remote-control signalling in two directions. It uses one 8-bit down counter. The counter is clocked by an external prescaler tick. In transmit mode it times each output pulse. In receive mode it measures the time since the last input edge. A small register interface lets software pick the direction, start and stop the block, load the counter, set the data level to send, and handle three interrupt flags.

In transmit mode, software writes a data bit and a pulse length. The block drives that bit on its output pin while the counter runs down. When the counter reaches zero, the block raises an underflow flag. Software then loads the next bit and length from its interrupt handler, so that pulses follow each other with no gap. Carrier modulation is added outside the block.

In receive mode, the input pin is sampled on each tick. A level change must persist for two consecutive samples to count as an edge; a shorter change is treated as noise. Rising and falling edges set separate flags, each with its own enable. Software reloads the counter at each edge and reads back the elapsed width later. The input pin is assumed to be already synchronous to the block clock.

Top module: `irpw_xcvr`

## Requirements
- R1: After reset, every register reads 0 and both `ir_out` and `irq` are 0. The registers are CTRL at address 0, LEN at 1, FLAG at 2 and IEN at 3.
- R2: A write to LEN loads the counter. The counter decrements by one on each cycle with `tick` high while CTRL.enable is 1. It holds its value on cycles without a tick, and it holds while the block is disabled.
- R3: When a decrement takes the counter from 1 to 0, FLAG bit 0 (underflow) is set in that same cycle. The counter then stays at 0, whatever ticks follow, until LEN is written again. Writing 0 to LEN sets no flag.
- R4: CTRL bit 0 is enable, bit 1 is mode (0 = transmit, 1 = receive) and bit 2 is the transmit data bit. All three read back as written.
- R5: `ir_out` equals the transmit data bit when the block is enabled in transmit mode. Otherwise it is 0.
- R6: When the block is enabled in receive mode, `ir_in` is sampled on each tick. A new level seen on two consecutive ticks sets FLAG bit 1 (rise, for a new level of 1) or FLAG bit 2 (fall, for a new level of 0). The flag is set on the second of those ticks.
- R7: A level change on `ir_in` that lasts for only one tick sample sets no edge flag.
- R8: A flag stays set until a FLAG write with a 1 in its bit position. Writing 0 bits has no effect. If a flag is set and cleared in the same cycle, it remains set.
- R9: `irq` is the OR of (FLAG AND IEN), with the IEN bits in the same positions as the FLAG bits.
- R10: While the block is disabled or in transmit mode, the edge filter follows `ir_in`. Enabling receive mode while `ir_in` is 1 therefore raises no edge flag.
- R11: In receive mode the counter also counts down from a software reload (for example 0xff), so the elapsed ticks can be read from LEN. Reaching 0 sets the underflow flag in this mode as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle prescaler enable pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the selected register (combinational) |
| ir_in | input | 1 | Serial receive input, synchronous to clk |
| ir_out | output | 1 | Transmit data level before carrier modulation |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value shows at the LEN read port in the cycle after the faulty tick. It also delays or advances the underflow flag and `irq`, and because the bench compares the model every cycle, a stuck run state appears as a missing underflow by the expected tick. If the edge filter holds a stale level, `irq` goes high early, shows a spurious edge flag on the tick after a glitch or after enable, or misses an edge by one tick. That difference shows on FLAG reads and on `irq` within one sampling tick. A wrong priority between flag set and clear shows as a flag that reads 0 one cycle after a tick that should have set it.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LEN  = 2'd1,
        REG_FLAG = 2'd2,
        REG_IEN  = 2'd3
    } reg_sel_e;

    localparam int NFLAG   = 3;
    localparam int FL_UF   = 0;
    localparam int FL_RISE = 1;
    localparam int FL_FALL = 2;

    typedef struct packed {
        logic txbit;
        logic rx_mode;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic fall;
        logic rise;
        logic uf;
    } flag_t;

    function automatic logic tx_level(input ctrl_t c);
        return c.enable & ~c.rx_mode & c.txbit;
    endfunction

    function automatic logic rx_active(input ctrl_t c);
        return c.enable & c.rx_mode;
    endfunction

endpackage

// File: rtl/irpw_regs.sv
module irpw_regs
    import irpw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [DW-1:0]     wdata,
    input  flag_t             set_flags,
    output ctrl_t             ctrl,
    output flag_t             flags,
    output logic [NFLAG-1:0]  ien,
    output logic              irq
);

    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flag_vec;

    assign set_vec = set_flags;
    assign clr_vec = (we && sel == REG_FLAG) ? wdata[NFLAG-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ien  <= '0;
        end else if (we) begin
            if (sel == REG_CTRL) ctrl <= ctrl_t'(wdata[2:0]);
            if (sel == REG_IEN)  ien  <= wdata[NFLAG-1:0];
        end
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flag_vec[i] <= 1'b0;
            else if (set_vec[i]) flag_vec[i] <= 1'b1;
            else if (clr_vec[i]) flag_vec[i] <= 1'b0;
        end
    end

    assign flags = flag_t'(flag_vec);
    assign irq   = |(flag_vec & ien);

endmodule

// File: rtl/irpw_len_cnt.sv
module irpw_len_cnt #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          tick,
    input  logic          enable,
    output logic [DW-1:0] count,
    output logic          running,
    output logic          underflow
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic step;
    assign step      = tick & enable & running & ~load;
    assign underflow = step & (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
        end else if (load) begin
            count   <= load_val;
            running <= (load_val != '0);
        end else if (step) begin
            count <= count - ONE;
            if (count == ONE) running <= 1'b0;
        end
    end

endmodule

// File: rtl/irpw_edge_filt.sv
module irpw_edge_filt (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tick,
    input  logic pin,
    output logic rise,
    output logic fall,
    output logic level
);

    logic sample;
    logic confirm;

    assign confirm = active & tick & (pin == sample) & (pin != level);
    assign rise    = confirm & pin;
    assign fall    = confirm & ~pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= 1'b0;
            level  <= 1'b0;
        end else if (!active) begin
            sample <= pin;
            level  <= pin;
        end else if (tick) begin
            sample <= pin;
            if (confirm) level <= pin;
        end
    end

endmodule

// File: rtl/irpw_xcvr.sv
module irpw_xcvr
    import irpw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ir_in,
    output logic          ir_out,
    output logic          irq
);

    localparam int PADC = DW - 3;
    localparam int PADF = DW - NFLAG;

    reg_sel_e         sel;
    ctrl_t            ctrl;
    flag_t            flags;
    flag_t            set_flags;
    logic [NFLAG-1:0] ien;
    logic [DW-1:0]    cnt_q;
    logic             run_q;
    logic             uf_ev;
    logic             rise_ev;
    logic             fall_ev;
    logic             filt_level;

    assign sel = reg_sel_e'(bus_addr);

    irpw_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .sel       (sel),
        .wdata     (bus_wdata),
        .set_flags (set_flags),
        .ctrl      (ctrl),
        .flags     (flags),
        .ien       (ien),
        .irq       (irq)
    );

    irpw_len_cnt #(.DW(DW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (bus_we && sel == REG_LEN),
        .load_val  (bus_wdata),
        .tick      (tick),
        .enable    (ctrl.enable),
        .count     (cnt_q),
        .running   (run_q),
        .underflow (uf_ev)
    );

    irpw_edge_filt u_filt (
        .clk    (clk),
        .rst    (rst),
        .active (rx_active(ctrl)),
        .tick   (tick),
        .pin    (ir_in),
        .rise   (rise_ev),
        .fall   (fall_ev),
        .level  (filt_level)
    );

    always_comb begin
        set_flags      = '0;
        set_flags.uf   = uf_ev;
        set_flags.rise = rise_ev;
        set_flags.fall = fall_ev;
    end

    always_comb begin
        case (sel)
            REG_CTRL: bus_rdata = {{PADC{1'b0}}, ctrl};
            REG_LEN:  bus_rdata = cnt_q;
            REG_FLAG: bus_rdata = {{PADF{1'b0}}, flags};
            default:  bus_rdata = {{PADF{1'b0}}, ien};
        endcase
    end

    assign ir_out = tx_level(ctrl);

endmodule

// File: rtl/irpw_chk.sv
module irpw_chk
    import irpw_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          bus_we,
    input logic [1:0]    bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          irq,
    input logic          ir_out,
    input logic [DW-1:0] cnt_q,
    input logic          run_q,
    input logic [2:0]    flag_bits,
    input logic [2:0]    ctrl_bits
);

    logic len_wr;
    logic flag_wr;
    assign len_wr  = bus_we && bus_addr == 2'd1;
    assign flag_wr = bus_we && bus_addr == 2'd2;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !len_wr) |=> $stable(cnt_q)); // R2

    AST_UF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_bits[0] && run_q && cnt_q == DW'(1) && !len_wr) |=> (flag_bits[0] && cnt_q == '0)); // R3

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !len_wr) |=> (cnt_q == '0)); // R3

    AST_NO_FLAG_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick) |=> ((flag_bits & ~$past(flag_bits)) == 3'b000)); // R8

    AST_NO_EDGE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_bits[0] && ctrl_bits[1])) |=> ((flag_bits[2:1] & ~$past(flag_bits[2:1])) == 2'b00)); // R10

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && bus_wdata[2:0] == 3'b111 && !tick) |=> !irq); // R8

    AST_RX_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
        ctrl_bits[1] |-> !ir_out); // R5

endmodule

bind irpw_xcvr irpw_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ir_out    (ir_out),
    .cnt_q     (cnt_q),
    .run_q     (run_q),
    .flag_bits (flags),
    .ctrl_bits (ctrl)
);

// File: tb/sim_irpw_xcvr.sv
module sim_irpw_xcvr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ir_in = 1'b0;
    logic       ir_out;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irpw_xcvr #(.DW(8)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ir_in(ir_in), .ir_out(ir_out), .irq(irq)
    );

    // behavioural reference state
    bit m_en, m_mode, m_tx, m_run, m_smp, m_lvl;
    int m_cnt;
    bit [2:0] m_flags, m_ien;

    always @(posedge clk) begin
        bit [2:0] setv, clrv;
        setv = 3'b000;
        clrv = 3'b000;
        if (rst) begin
            m_en = 0; m_mode = 0; m_tx = 0; m_run = 0; m_smp = 0; m_lvl = 0;
            m_cnt = 0; m_flags = 0; m_ien = 0;
        end else begin
            if (m_en && m_mode) begin
                if (tick) begin
                    if (ir_in == m_smp && ir_in != m_lvl) begin
                        if (ir_in) setv[1] = 1'b1; else setv[2] = 1'b1;
                        m_lvl = ir_in;
                    end
                    m_smp = ir_in;
                end
            end else begin
                m_smp = ir_in;
                m_lvl = ir_in;
            end
            if (bus_we && bus_addr == 2'd1) begin
                m_cnt = bus_wdata;
                m_run = (bus_wdata != 0);
            end else if (tick && m_en && m_run) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    setv[0] = 1'b1;
                    m_run = 0;
                end
            end
            if (bus_we && bus_addr == 2'd2) clrv = bus_wdata[2:0];
            m_flags = (m_flags & ~clrv) | setv;
            if (bus_we && bus_addr == 2'd0) begin
                m_en = bus_wdata[0]; m_mode = bus_wdata[1]; m_tx = bus_wdata[2];
            end
            if (bus_we && bus_addr == 2'd3) m_ien = bus_wdata[2:0];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        int exp_rd;
        @(negedge clk);
        #2;
        if (!rst && !done) begin
            case (bus_addr)
                2'd0: exp_rd = {m_tx, m_mode, m_en};
                2'd1: exp_rd = m_cnt;
                2'd2: exp_rd = m_flags;
                default: exp_rd = m_ien;
            endcase
            chk("R4 rdata vs model", bus_rdata, exp_rd);
            chk("R5 ir_out vs model", ir_out, m_en & ~m_mode & m_tx);
            chk("R9 irq vs model", irq, |(m_flags & m_ien));
        end
    end

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input bit [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic expect_reg(input string tag, input bit [1:0] a, input int exp);
        int v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_reg("R1 CTRL reset", 2'd0, 0);
        expect_reg("R1 LEN reset", 2'd1, 0);
        expect_reg("R1 FLAG reset", 2'd2, 0);
        expect_reg("R1 IEN reset", 2'd3, 0);
        chk("R1 ir_out reset", ir_out, 0);
        chk("R1 irq reset", irq, 0);

        // transmit
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h05);
        expect_reg("R4 CTRL readback", 2'd0, 5);
        chk("R5 tx drives data bit", ir_out, 1);
        wr(2'd1, 8'd3);
        ticks(2);
        expect_reg("R2 LEN after two ticks", 2'd1, 1);
        expect_reg("R2 no flag yet", 2'd2, 0);
        repeat (3) @(negedge clk);
        expect_reg("R2 LEN holds without tick", 2'd1, 1);
        ticks(1);
        expect_reg("R3 LEN at zero", 2'd1, 0);
        expect_reg("R3 underflow flag", 2'd2, 1);
        chk("R9 irq on underflow", irq, 1);
        ticks(2);
        expect_reg("R3 counter stopped", 2'd1, 0);
        wr(2'd0, 8'h01);
        chk("R5 tx drives zero bit", ir_out, 0);
        wr(2'd2, 8'h00);
        expect_reg("R8 zero write ignored", 2'd2, 1);
        wr(2'd2, 8'h01);
        expect_reg("R8 write one clears", 2'd2, 0);
        chk("R9 irq drops on clear", irq, 0);
        wr(2'd1, 8'd0);
        ticks(2);
        expect_reg("R3 zero load sets nothing", 2'd2, 0);
        wr(2'd1, 8'd1);
        @(negedge clk);
        tick = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h01;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
        expect_reg("R8 set wins over clear", 2'd2, 1);
        wr(2'd2, 8'h07);
        wr(2'd0, 8'h04);
        chk("R5 disabled output low", ir_out, 0);
        wr(2'd1, 8'd5);
        ticks(3);
        expect_reg("R2 disabled holds count", 2'd1, 5);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h01);
        ticks(5);
        expect_reg("R3 flag set with irq masked", 2'd2, 1);
        chk("R9 irq masked", irq, 0);
        wr(2'd2, 8'h07);

        // receive
        wr(2'd0, 8'h00);
        ir_in = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd0, 8'h03);
        ticks(3);
        expect_reg("R10 no false edge on enable", 2'd2, 0);
        wr(2'd3, 8'h06);
        ir_in = 1'b0;
        ticks(1);
        ir_in = 1'b1;
        ticks(2);
        expect_reg("R7 glitch ignored", 2'd2, 0);
        chk("R7 irq quiet", irq, 0);
        ir_in = 1'b0;
        ticks(1);
        expect_reg("R6 one sample not enough", 2'd2, 0);
        ticks(1);
        expect_reg("R6 fall flag", 2'd2, 4);
        chk("R6 irq on fall", irq, 1);
        wr(2'd2, 8'h04);
        wr(2'd1, 8'hff);
        ir_in = 1'b1;
        ticks(2);
        expect_reg("R6 rise flag", 2'd2, 2);
        expect_reg("R11 width measured", 2'd1, 253);
        wr(2'd3, 8'h04);
        chk("R9 rise masked", irq, 0);
        wr(2'd1, 8'd2);
        ticks(2);
        expect_reg("R11 rx underflow", 2'd2, 3);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule